// File: doc/BRIEF.md
# Sensor Min/Max Alarm Monitor

This block watches a stream of 12-bit conversion results, each tagged with the channel it belongs to. One channel carries die temperature and the others carry supply rails. Every accepted sample updates that channel's latest value and its running peak and floor. The same sample is also compared against that channel's alarm window. A temperature sample above a separate shutdown limit raises a latched power-down request, which stays set until reset or until software clears it.

A small register port lets software program the upper and lower thresholds, the temperature release level and the shutdown limit. The same port reads the latest values, the extremes and the alarm status. Reads are combinational and have no side effects, so software can poll at any time while monitoring carries on. Each register address is formed as `{kind[2:0], channel}`.

Top module: `sensmon_top`

## Requirements
- R1: A sample with `smp_valid` high is taken at the next rising clock edge. From the cycle after that, kind 0 (latest) for that channel reads back the sample value, zero-extended to 16 bits.
- R2: After reset, every peak register (kind 1) reads 0x000 and every floor register (kind 2) reads 0xFFF. The first sample on a channel therefore sets both of them to that sample's value.
- R3: The peak register holds the largest sample seen since reset on its channel, and the floor register holds the smallest.
- R4: Reading any address changes no state. Results, extremes, alarms and the shutdown request stay the same across any number of reads.
- R5: A supply channel's alarm bit goes to 1 when a sample is strictly above its upper threshold (kind 3) or strictly below its lower threshold (kind 4). A later sample that is in range, including one exactly equal to a threshold, clears the bit. Between samples the bit holds its value.
- R6: The temperature channel (channel 0) alarm bit is set by a sample strictly above its upper threshold. It is cleared only by a sample strictly below the release level (kind 5, channel field 0). Any other sample leaves the bit as it was.
- R7: A temperature-channel sample strictly above the shutdown limit (kind 5, channel field 1) sets `shutdown_o` from the next cycle. Samples on other channels never set it.
- R8: `shutdown_o` stays set until reset or until a write to the status word (kind 5, channel field 2) with bit 15 = 1. A write to that word with bit 15 = 0 leaves it set.
- R9: If a shutdown-setting sample and a clearing write arrive in the same cycle, `shutdown_o` is set afterwards.
- R10: Thresholds read back as written. Their reset values are: upper 0xFFF, lower 0x000, release level 0x000, shutdown limit 0xFFF. The status word reads alarm bits in bits [NUM_CH-1:0] and the shutdown request in bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | CH_W (2) | Channel of the sample |
| smp_value | input | 12 | Conversion result |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3+CH_W (5) | Register address `{kind, channel}` |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| alarm_o | output | NUM_CH (4) | Per-channel alarm bits |
| shutdown_o | output | 1 | Latched power-down request |

## Verification
Two events can land in the same cycle: a temperature sample that crosses the shutdown limit, and a software write that clears the shutdown request. The bench drives both in one cycle, with the sample strobe and the write strobe raised together. It then checks that `shutdown_o` is still high on the following cycle. A clearing write made on its own afterwards must drop the request, which shows that the clear path works and that the set path won the earlier collision.

// File: rtl/sensmon_pkg.sv
package sensmon_pkg;
    localparam int SAMPLE_W    = 12;
    localparam int REG_W       = 16;
    localparam int KIND_W      = 3;
    localparam int SD_FLAG_BIT = REG_W - 1;

    // Channel-field selectors used under the miscellaneous kind
    localparam int MISC_HYST   = 0;
    localparam int MISC_LIMIT  = 1;
    localparam int MISC_STATUS = 2;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [REG_W-1:0]    regword_t;

    typedef enum logic [KIND_W-1:0] {
        RK_LAST  = 3'd0,
        RK_PEAK  = 3'd1,
        RK_FLOOR = 3'd2,
        RK_HIGH  = 3'd3,
        RK_LOW   = 3'd4,
        RK_MISC  = 3'd5
    } reg_kind_e;

    typedef struct packed {
        sample_t high;
        sample_t low;
    } window_t;

    typedef struct packed {
        sample_t last;
        sample_t peak;
        sample_t floor;
    } history_t;

    localparam sample_t ALL_ONES = '1;
    localparam sample_t ALL_ZERO = '0;

    function automatic logic out_of_window(sample_t v, window_t w);
        return (v > w.high) || (v < w.low);
    endfunction

    function automatic regword_t widen(sample_t v);
        return regword_t'(v);
    endfunction
endpackage

// File: rtl/sm_chan_track.sv
module sm_chan_track
    import sensmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hit,
    input  sample_t  value,
    output history_t hist
);
    history_t hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q.last  <= ALL_ZERO;
            hist_q.peak  <= ALL_ZERO;
            hist_q.floor <= ALL_ONES;
        end else if (hit) begin
            hist_q.last <= value;
            if (value > hist_q.peak)  hist_q.peak  <= value;
            if (value < hist_q.floor) hist_q.floor <= value;
        end
    end

    assign hist = hist_q;

    assert_last_capture_R1: assert property (@(posedge clk) disable iff (rst)
        hit |=> hist_q.last == $past(value));

    assert_extremes_bound_R3: assert property (@(posedge clk) disable iff (rst)
        hit |=> (hist_q.peak >= hist_q.last) && (hist_q.floor <= hist_q.last));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(hist_q));
endmodule

// File: rtl/sm_alarm_unit.sv
module sm_alarm_unit
    import sensmon_pkg::*;
#(
    parameter bit HYSTERETIC = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    hit,
    input  sample_t value,
    input  window_t win,
    input  sample_t release_level,
    output logic    alarm
);
    logic alarm_q;

    generate
        if (HYSTERETIC) begin : g_temp
            logic unused_low;
            assign unused_low = ^win.low;

            always_ff @(posedge clk) begin
                if (rst)
                    alarm_q <= 1'b0;
                else if (hit) begin
                    if (value > win.high)
                        alarm_q <= 1'b1;
                    else if (value < release_level)
                        alarm_q <= 1'b0;
                end
            end

            assert_hyst_hold_R6: assert property (@(posedge clk) disable iff (rst)
                hit && (value >= release_level) && (value <= win.high)
                |=> alarm_q == $past(alarm_q));
        end else begin : g_supply
            logic unused_release;
            assign unused_release = ^release_level;

            always_ff @(posedge clk) begin
                if (rst)
                    alarm_q <= 1'b0;
                else if (hit)
                    alarm_q <= out_of_window(value, win);
            end

            assert_in_range_clear_R5: assert property (@(posedge clk) disable iff (rst)
                hit && (value <= win.high) && (value >= win.low) |=> !alarm_q);
        end
    endgenerate

    assign alarm = alarm_q;

    assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(alarm_q));
endmodule

// File: rtl/sm_cfg_regs.sv
module sm_cfg_regs
    import sensmon_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  reg_kind_e              kind,
    input  logic [CH_W-1:0]        chan,
    input  regword_t               wdata,
    output window_t [NUM_CH-1:0]   win,
    output sample_t                hyst_level,
    output sample_t                sd_limit,
    output logic                   sd_clear
);
    window_t [NUM_CH-1:0] win_q;
    sample_t              hyst_q;
    sample_t              lim_q;
    logic                 chan_ok;
    sample_t              wval;
    logic                 unused_hi;

    assign chan_ok   = int'(chan) < NUM_CH;
    assign wval      = wdata[SAMPLE_W-1:0];
    assign unused_hi = ^wdata[SD_FLAG_BIT-1:SAMPLE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CH; i++) begin
                win_q[i].high <= ALL_ONES;
                win_q[i].low  <= ALL_ZERO;
            end
            hyst_q <= ALL_ZERO;
            lim_q  <= ALL_ONES;
        end else if (wr_en) begin
            case (kind)
                RK_HIGH: if (chan_ok) win_q[chan].high <= wval;
                RK_LOW:  if (chan_ok) win_q[chan].low  <= wval;
                RK_MISC: begin
                    if (int'(chan) == MISC_HYST)  hyst_q <= wval;
                    if (int'(chan) == MISC_LIMIT) lim_q  <= wval;
                end
                default: ;
            endcase
        end
    end

    assign sd_clear   = wr_en && (kind == RK_MISC) && (int'(chan) == MISC_STATUS)
                        && wdata[SD_FLAG_BIT];
    assign win        = win_q;
    assign hyst_level = hyst_q;
    assign sd_limit   = lim_q;

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(win_q) && $stable(hyst_q) && $stable(lim_q));
endmodule

// File: rtl/sensmon_top.sv
module sensmon_top
    import sensmon_pkg::*;
#(
    parameter int NUM_CH  = 4,
    parameter int TEMP_CH = 0,
    parameter int CH_W    = $clog2(NUM_CH),
    parameter int ADDR_W  = KIND_W + CH_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [CH_W-1:0]     smp_chan,
    input  logic [SAMPLE_W-1:0] smp_value,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic [NUM_CH-1:0]   alarm_o,
    output logic                shutdown_o
);
    reg_kind_e            addr_kind;
    logic [CH_W-1:0]      addr_chan;
    window_t [NUM_CH-1:0] win;
    sample_t              hyst_level;
    sample_t              sd_limit;
    logic                 sd_clear;
    history_t [NUM_CH-1:0] hist;
    logic [NUM_CH-1:0]    alarm;
    logic                 temp_trip;
    logic                 sd_q;

    assign addr_kind = reg_kind_e'(reg_addr[ADDR_W-1:CH_W]);
    assign addr_chan = reg_addr[CH_W-1:0];

    sm_cfg_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_we),
        .kind       (addr_kind),
        .chan       (addr_chan),
        .wdata      (reg_wdata),
        .win        (win),
        .hyst_level (hyst_level),
        .sd_limit   (sd_limit),
        .sd_clear   (sd_clear)
    );

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            logic hit;
            assign hit = smp_valid && (smp_chan == CH_W'(ch));

            sm_chan_track u_track (
                .clk   (clk),
                .rst   (rst),
                .hit   (hit),
                .value (smp_value),
                .hist  (hist[ch])
            );

            sm_alarm_unit #(.HYSTERETIC(ch == TEMP_CH)) u_alarm (
                .clk           (clk),
                .rst           (rst),
                .hit           (hit),
                .value         (smp_value),
                .win           (win[ch]),
                .release_level (hyst_level),
                .alarm         (alarm[ch])
            );
        end
    endgenerate

    assign temp_trip = smp_valid && (smp_chan == CH_W'(TEMP_CH)) && (smp_value > sd_limit);

    // Set has priority over the software clear
    always_ff @(posedge clk) begin
        if (rst)
            sd_q <= 1'b0;
        else if (temp_trip)
            sd_q <= 1'b1;
        else if (sd_clear)
            sd_q <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        case (addr_kind)
            RK_LAST:  if (int'(addr_chan) < NUM_CH) reg_rdata = widen(hist[addr_chan].last);
            RK_PEAK:  if (int'(addr_chan) < NUM_CH) reg_rdata = widen(hist[addr_chan].peak);
            RK_FLOOR: if (int'(addr_chan) < NUM_CH) reg_rdata = widen(hist[addr_chan].floor);
            RK_HIGH:  if (int'(addr_chan) < NUM_CH) reg_rdata = widen(win[addr_chan].high);
            RK_LOW:   if (int'(addr_chan) < NUM_CH) reg_rdata = widen(win[addr_chan].low);
            RK_MISC: begin
                if (int'(addr_chan) == MISC_HYST)  reg_rdata = widen(hyst_level);
                if (int'(addr_chan) == MISC_LIMIT) reg_rdata = widen(sd_limit);
                if (int'(addr_chan) == MISC_STATUS) begin
                    reg_rdata[NUM_CH-1:0]  = alarm;
                    reg_rdata[SD_FLAG_BIT] = sd_q;
                end
            end
            default: ;
        endcase
    end

    assign alarm_o    = alarm;
    assign shutdown_o = sd_q;

    assert_trip_latch_R7: assert property (@(posedge clk) disable iff (rst)
        temp_trip |=> shutdown_o);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        shutdown_o && !sd_clear |=> shutdown_o);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        temp_trip && sd_clear |=> shutdown_o);

    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (rst)
        sd_clear && !temp_trip |=> !shutdown_o);
endmodule

// File: tb/tb_sensmon_top.sv
`timescale 1ns/1ps
module tb_sensmon_top;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [1:0]  smp_chan = '0;
    logic [11:0] smp_value = '0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  alarm_o;
    logic        shutdown_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        int          src;   // 0 read data, 1 alarm vector, 2 shutdown
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    sensmon_top dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_value(smp_value), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_o(alarm_o),
        .shutdown_o(shutdown_o)
    );

    always #2 clk = ~clk;

    // Monitor: pops one expected item per cycle, mid-cycle
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = sb.pop_front();
            case (it.src)
                0:       act = reg_rdata;
                1:       act = {12'b0, alarm_o};
                default: act = {15'b0, shutdown_o};
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%04h expected 0x%04h", it.tag, act, it.exp);
            end
        end
    end

    function automatic logic [4:0] mk(int kind, int ch);
        return {kind[2:0], ch[1:0]};
    endfunction

    task automatic tick();
        @(posedge clk); #1;
        smp_valid = 1'b0;
        reg_we    = 1'b0;
    endtask

    task automatic sample(int ch, logic [11:0] v);
        tick();
        smp_valid = 1'b1; smp_chan = ch[1:0]; smp_value = v;
    endtask

    task automatic wr(int kind, int ch, logic [15:0] d);
        tick();
        reg_we = 1'b1; reg_addr = mk(kind, ch); reg_wdata = d;
    endtask

    task automatic exp_reg(int kind, int ch, logic [15:0] e, string tag);
        item_t it;
        tick();
        reg_addr = mk(kind, ch);
        it.src = 0; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic exp_port(int src, logic [15:0] e, string tag);
        item_t it;
        tick();
        it.src = src; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // Reset state
        exp_reg(0, 1, 16'h0000, "R1 latest reset");
        exp_reg(1, 1, 16'h0000, "R2 peak reset");
        exp_reg(2, 1, 16'h0FFF, "R2 floor reset");
        exp_reg(3, 1, 16'h0FFF, "R10 upper reset");
        exp_reg(4, 1, 16'h0000, "R10 lower reset");
        exp_reg(5, 1, 16'h0FFF, "R10 limit reset");
        exp_reg(5, 2, 16'h0000, "R10 status reset");
        exp_port(2, 16'h0000, "R7 shutdown reset");

        // First sample sets both extremes
        sample(1, 12'h400);
        exp_reg(0, 1, 16'h0400, "R1 latest capture");
        exp_reg(1, 1, 16'h0400, "R2 first peak");
        exp_reg(2, 1, 16'h0400, "R2 first floor");

        sample(1, 12'h500);
        sample(1, 12'h100);
        exp_reg(0, 1, 16'h0100, "R1 latest update");
        exp_reg(1, 1, 16'h0500, "R3 peak");
        exp_reg(2, 1, 16'h0100, "R3 floor");
        sample(1, 12'h300);
        exp_reg(1, 1, 16'h0500, "R3 peak kept");
        exp_reg(2, 1, 16'h0100, "R3 floor kept");

        // Reads have no side effect
        for (int i = 0; i < 6; i++) exp_reg(i, 2, (i == 3) ? 16'h0FFF : ((i == 2) ? 16'h0FFF : 16'h0000), "R4 sweep");
        exp_reg(0, 1, 16'h0300, "R4 latest after reads");
        exp_reg(1, 1, 16'h0500, "R4 peak after reads");

        // Supply window on channel 2
        wr(3, 2, 16'h0800);
        wr(4, 2, 16'h0200);
        exp_reg(3, 2, 16'h0800, "R10 upper readback");
        exp_reg(4, 2, 16'h0200, "R10 lower readback");
        sample(2, 12'h900);
        exp_port(1, 16'h0004, "R5 over upper");
        exp_port(1, 16'h0004, "R5 hold between samples");
        sample(2, 12'h800);
        exp_port(1, 16'h0000, "R5 equal upper clears");
        sample(2, 12'h1FF);
        exp_port(1, 16'h0004, "R5 under lower");
        sample(2, 12'h200);
        exp_port(1, 16'h0000, "R5 equal lower clears");

        // Temperature hysteresis
        wr(3, 0, 16'h0A00);
        wr(5, 0, 16'h0900);
        exp_reg(5, 0, 16'h0900, "R10 release readback");
        sample(0, 12'hA01);
        exp_port(1, 16'h0001, "R6 set above upper");
        sample(0, 12'h950);
        exp_port(1, 16'h0001, "R6 hold in band");
        sample(0, 12'h900);
        exp_port(1, 16'h0001, "R6 hold at release");
        sample(0, 12'h8FF);
        exp_port(1, 16'h0000, "R6 clear below release");
        sample(0, 12'h950);
        exp_port(1, 16'h0000, "R6 stays clear in band");

        // Shutdown limit
        wr(5, 1, 16'h0C00);
        exp_reg(5, 1, 16'h0C00, "R10 limit readback");
        sample(1, 12'hFFF);
        exp_port(2, 16'h0000, "R7 other channel ignored");
        sample(0, 12'hC00);
        exp_port(2, 16'h0000, "R7 equal limit no trip");
        sample(0, 12'hC01);
        exp_port(2, 16'h0001, "R7 trip");
        sample(0, 12'h100);
        exp_port(2, 16'h0001, "R8 latched");
        exp_reg(5, 2, 16'h8000, "R10 status word");
        wr(5, 2, 16'h0000);
        exp_port(2, 16'h0001, "R8 write without flag");
        wr(5, 2, 16'h8000);
        exp_port(2, 16'h0000, "R8 clear by write");

        // Collision: trip and clear in one cycle
        tick();
        smp_valid = 1'b1; smp_chan = 2'd0; smp_value = 12'hC05;
        reg_we = 1'b1; reg_addr = mk(5, 2); reg_wdata = 16'h8000;
        exp_port(2, 16'h0001, "R9 set wins");
        exp_reg(5, 2, 16'h8001, "R9 status after collision");
        wr(5, 2, 16'h8000);
        exp_port(2, 16'h0000, "R9 later clear");

        tick(); tick();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule